// File: doc/BRIEF.md
# Serial Broadcast Packet Receiver

This block listens to a continuous 8N1 asynchronous serial stream and extracts fixed-length broadcast packets from it. Each packet carries date, time, speed, position, route and train identity in a 14-byte payload. The payload is wrapped by a leading marker byte, a trailing marker byte and a one-byte XOR block check. The receiver oversamples the line, rebuilds bytes and hunts for the leading marker. It collects the packet into a primary buffer and checks the trailing marker and the block check.

A packet that passes every check is copied in a single cycle into a secondary buffer, and a ready flag is raised. The consumer reads the secondary buffer at its own pace through a byte-addressed port and acknowledges it. The acknowledge clears the buffer. The primary side keeps receiving the whole time, so no packet is lost while the consumer is slow. If a second good packet completes before the acknowledge, it replaces the first and an overrun flag is set. Rejected packets increment a saturating error counter. Line-level faults such as a low stop bit or a stalled packet abort the packet without counting it.

Top module: `bcast_pkt_rx`

## Requirements
- R1: Bytes are received as 1 start bit, 8 data bits sent LSB first, and 1 stop bit. One bit lasts TICK_DIV*16 clock cycles, and each bit is sampled near its middle.
- R2: A low pulse on the idle line that is no longer low at the middle of the would-be start bit is ignored and produces no byte.
- R3: A packet is 17 bytes. Byte 0 is 0x02, bytes 1 to 14 are the payload, byte 15 is 0x03, and byte 16 equals the XOR of bytes 0 to 14. While hunting, every byte other than 0x02 is ignored.
- R4: When the last byte of a valid packet is received, the next clock raises pkt_ready. rd_data then shows byte rd_addr (addresses 0 to 16) of that packet combinationally. Addresses 17 to 31 read 0.
- R5: Reception into the primary buffer continues while pkt_ready is high, so a packet sent during that time is captured in full.
- R6: When byte 15 is not 0x03 or byte 16 does not match the XOR, the packet is dropped and err_count rises by one, saturating at all ones. Hunting for 0x02 then restarts.
- R7: A byte whose stop bit samples low drops the packet in progress, leaves err_count unchanged and restarts the hunt.
- R8: Inside a packet, an idle line lasting GAP_BITS bit times without a new start bit aborts the packet and leaves err_count unchanged. Shorter idle gaps are tolerated.
- R9: pkt_ack clears pkt_ready and overrun and zeroes the secondary buffer. While pkt_ready is low, rd_data reads 0.
- R10: A valid packet that completes while pkt_ready is high and pkt_ack is low overwrites the secondary buffer and sets overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_line | input | 1 | Serial input, idle high |
| rd_addr | input | 5 | Byte index into the validated packet |
| rd_data | output | 8 | Byte of the validated packet at rd_addr |
| pkt_ready | output | 1 | Validated packet available |
| pkt_ack | input | 1 | Consumer done, one-cycle pulse |
| overrun | output | 1 | A ready packet was replaced before acknowledge |
| err_count | output | ERR_W | Saturating count of rejected packets |

## Verification
The bench targets a short glitch between bytes. A receiver without the mid-start recheck would insert a bogus 0xFF byte, shift the trailing marker out of place, and drop a good packet with an error count. It drives wrong trailing markers and wrong checks until the counter saturates. Each packet that should be dropped is watched for a stray ready, and a counter that wraps would show 0 instead of 3. A low stop bit and a long mid-packet gap must both abort silently, while a shorter gap must still deliver the packet. Two packets are sent without acknowledge to show that the second overwrites the first, that overrun is set, and that an acknowledge clears the flag and the buffer.

// File: rtl/bcast_rx_pkg.sv
package bcast_rx_pkg;
  localparam int PKT_LEN = 17;
  localparam int OSR     = 16;
  localparam int ADDR_W  = $clog2(PKT_LEN);
  localparam int ETX_IDX = PKT_LEN - 2;
  localparam int BCC_IDX = PKT_LEN - 1;
  localparam logic [7:0] MARK_HEAD = 8'h02;
  localparam logic [7:0] MARK_TAIL = 8'h03;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_e;
  typedef enum logic {FR_HUNT, FR_COLLECT} fr_state_e;

  // running block check: fold one byte into the accumulator
  function automatic logic [7:0] bcc_step(input logic [7:0] acc, input logic [7:0] b);
    return acc ^ b;
  endfunction

  // bit time expressed in oversampling ticks
  function automatic int bit_ticks(input int nbits);
    return nbits * OSR;
  endfunction
endpackage

// File: rtl/bcast_tick_gen.sv
module bcast_tick_gen #(
  parameter int DIV = 326
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == CW'(DIV - 1)) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/bcast_uart_rx.sv
module bcast_uart_rx
  import bcast_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rx_line,
  output logic       byte_vld,
  output logic [7:0] byte_data,
  output logic       stop_err,
  output logic       busy
);
  localparam int HALF = OSR / 2;

  rx_state_e  state;
  logic [1:0] sync;
  logic [3:0] sub;
  logic [2:0] nbit;
  logic       line;

  assign line = sync[1];
  assign busy = (state != RX_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) sync <= 2'b11;
    else        sync <= {sync[0], rx_line};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= RX_IDLE;
      sub       <= '0;
      nbit      <= '0;
      byte_data <= '0;
      byte_vld  <= 1'b0;
      stop_err  <= 1'b0;
    end else begin
      byte_vld <= 1'b0;
      stop_err <= 1'b0;
      if (tick) begin
        unique case (state)
          RX_IDLE: if (!line) begin
            state <= RX_START;
            sub   <= '0;
          end
          RX_START: if (sub == 4'(HALF - 1)) begin
            sub   <= '0;
            nbit  <= '0;
            state <= line ? RX_IDLE : RX_DATA;
          end else sub <= sub + 1'b1;
          RX_DATA: if (sub == 4'(OSR - 1)) begin
            sub       <= '0;
            byte_data <= {line, byte_data[7:1]};
            if (nbit == 3'd7) state <= RX_STOP;
            else              nbit  <= nbit + 1'b1;
          end else sub <= sub + 1'b1;
          RX_STOP: if (sub == 4'(OSR - 1)) begin
            sub   <= '0;
            state <= RX_IDLE;
            if (line) byte_vld <= 1'b1;
            else      stop_err <= 1'b1;
          end else sub <= sub + 1'b1;
          default: state <= RX_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/bcast_framer.sv
module bcast_framer
  import bcast_rx_pkg::*;
#(
  parameter int ERR_W    = 8,
  parameter int GAP_BITS = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              byte_vld,
  input  logic [7:0]        byte_data,
  input  logic              stop_err,
  input  logic              rx_busy,
  input  logic              pkt_ack,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic              pkt_ready,
  output logic              overrun,
  output logic [ERR_W-1:0]  err_count,
  output logic              evt_good,
  output logic              evt_bad,
  output logic              evt_abort
);
  localparam int GAP_TICKS = bit_ticks(GAP_BITS);
  localparam int GW        = $clog2(GAP_TICKS + 1);
  localparam int PW        = $clog2(PKT_LEN - 1);

  fr_state_e         fr_state;
  logic [ADDR_W-1:0] idx;
  logic [7:0]        acc;
  logic [GW-1:0]     gap_cnt;
  logic [7:0]        pri [PKT_LEN-1];
  logic [7:0]        sec [PKT_LEN];
  logic              in_pkt, at_etx, at_bcc, gap_hit;

  assign in_pkt    = (fr_state == FR_COLLECT);
  assign at_etx    = (idx == ADDR_W'(ETX_IDX));
  assign at_bcc    = (idx == ADDR_W'(BCC_IDX));
  assign gap_hit   = in_pkt && !rx_busy && tick && (gap_cnt == GW'(GAP_TICKS - 1));
  assign evt_good  = in_pkt && byte_vld && at_bcc && (byte_data == acc);
  assign evt_bad   = in_pkt && byte_vld &&
                     ((at_etx && byte_data != MARK_TAIL) || (at_bcc && byte_data != acc));
  assign evt_abort = in_pkt && (stop_err || gap_hit);

  // idle-line watchdog inside a packet
  always_ff @(posedge clk) begin
    if (!rst_n || !in_pkt || rx_busy || byte_vld) gap_cnt <= '0;
    else if (tick)                                gap_cnt <= gap_cnt + 1'b1;
  end

  // packet sequencing and running check
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fr_state <= FR_HUNT;
      idx      <= '0;
      acc      <= '0;
    end else if (evt_good || evt_bad || evt_abort) begin
      fr_state <= FR_HUNT;
    end else if (byte_vld) begin
      if (!in_pkt) begin
        if (byte_data == MARK_HEAD) begin
          fr_state <= FR_COLLECT;
          idx      <= ADDR_W'(1);
          acc      <= bcc_step(8'h00, byte_data);
        end
      end else begin
        if (idx < ADDR_W'(ETX_IDX)) acc <= bcc_step(acc, byte_data);
        idx <= idx + 1'b1;
      end
    end
  end

  // primary buffer: datapath only
  always_ff @(posedge clk) begin
    if (byte_vld && !at_bcc && (in_pkt || byte_data == MARK_HEAD))
      pri[in_pkt ? idx[PW-1:0] : '0] <= byte_data;
  end

  // secondary buffer and consumer handshake
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < PKT_LEN; i++) sec[i] <= '0;
      pkt_ready <= 1'b0;
      overrun   <= 1'b0;
    end else if (evt_good) begin
      for (int i = 0; i < BCC_IDX; i++) sec[i] <= pri[i];
      sec[BCC_IDX] <= byte_data;
      pkt_ready    <= 1'b1;
      overrun      <= pkt_ready && !pkt_ack;
    end else if (pkt_ack) begin
      for (int i = 0; i < PKT_LEN; i++) sec[i] <= '0;
      pkt_ready <= 1'b0;
      overrun   <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                          err_count <= '0;
    else if (evt_bad && err_count != '1) err_count <= err_count + 1'b1;
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < PKT_LEN; i++)
      if (rd_addr == ADDR_W'(i)) rd_data = sec[i];
  end
endmodule

// File: rtl/bcast_pkt_rx.sv
module bcast_pkt_rx
  import bcast_rx_pkg::*;
#(
  parameter int TICK_DIV = 326,
  parameter int GAP_BITS = 20,
  parameter int ERR_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_line,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic              pkt_ready,
  input  logic              pkt_ack,
  output logic              overrun,
  output logic [ERR_W-1:0]  err_count
);
  logic       tick;
  logic       byte_vld, stop_err, rx_busy;
  logic [7:0] byte_data;
  logic       evt_good, evt_bad, evt_abort;

  bcast_tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  bcast_uart_rx u_uart (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rx_line(rx_line),
    .byte_vld(byte_vld), .byte_data(byte_data), .stop_err(stop_err), .busy(rx_busy)
  );

  bcast_framer #(.ERR_W(ERR_W), .GAP_BITS(GAP_BITS)) u_framer (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .byte_vld(byte_vld), .byte_data(byte_data), .stop_err(stop_err), .rx_busy(rx_busy),
    .pkt_ack(pkt_ack), .rd_addr(rd_addr), .rd_data(rd_data),
    .pkt_ready(pkt_ready), .overrun(overrun), .err_count(err_count),
    .evt_good(evt_good), .evt_bad(evt_bad), .evt_abort(evt_abort)
  );
endmodule

// File: rtl/bcast_pkt_rx_chk.sv
module bcast_pkt_rx_chk #(
  parameter int ERR_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             byte_vld,
  input logic             stop_err,
  input logic             evt_good,
  input logic             evt_bad,
  input logic             evt_abort,
  input logic             pkt_ack,
  input logic             pkt_ready,
  input logic             overrun,
  input logic [ERR_W-1:0] err_count,
  input logic [7:0]       rd_data
);
  AST_READY_AFTER_GOOD: assert property (@(posedge clk) disable iff (!rst_n) evt_good |=> pkt_ready); // R4
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (pkt_ack && !evt_good) |=> (!pkt_ready && !overrun)); // R9
  AST_IDLE_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n) !pkt_ready |-> (rd_data == 8'h00)); // R9
  AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n) (evt_good && pkt_ready && !pkt_ack) |=> overrun); // R10
  AST_ERR_STEP: assert property (@(posedge clk) disable iff (!rst_n) !$stable(err_count) |-> (err_count == $past(err_count) + ERR_W'(1))); // R6
  AST_ERR_ONLY_ON_BAD: assert property (@(posedge clk) disable iff (!rst_n) !$stable(err_count) |-> $past(evt_bad)); // R6
  AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({evt_good, evt_bad, evt_abort})); // R3
  AST_BYTE_OR_STOP_FAULT: assert property (@(posedge clk) disable iff (!rst_n) !(byte_vld && stop_err)); // R7
endmodule

bind bcast_pkt_rx bcast_pkt_rx_chk #(.ERR_W(ERR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .stop_err(stop_err),
  .evt_good(evt_good), .evt_bad(evt_bad), .evt_abort(evt_abort),
  .pkt_ack(pkt_ack), .pkt_ready(pkt_ready), .overrun(overrun),
  .err_count(err_count), .rd_data(rd_data)
);

// File: tb/bcast_pkt_rx_test.sv
`timescale 1ns/1ps
module bcast_pkt_rx_test;
  localparam int TDIV = 2;
  localparam int BITC = TDIV * 16;
  localparam int EW   = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rx_line = 1'b1;
  logic          pkt_ack = 1'b0;
  logic [4:0]    rd_addr = '0;
  logic [7:0]    rd_data;
  logic          pkt_ready, overrun;
  logic [EW-1:0] err_count;

  always #10 clk = ~clk;

  bcast_pkt_rx #(.TICK_DIV(TDIV), .GAP_BITS(20), .ERR_W(EW)) uut (
    .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .rd_addr(rd_addr), .rd_data(rd_data),
    .pkt_ready(pkt_ready), .pkt_ack(pkt_ack), .overrun(overrun), .err_count(err_count)
  );

  int            n_chk = 0;
  int            n_fail = 0;
  bit            hold_ack = 1'b0;
  logic [135:0]  exp_q[$];
  string         tag_q[$];

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wait_bits(input int n);
    rx_line = 1'b1;
    repeat (n * BITC) @(negedge clk);
  endtask

  task automatic drive_byte(input logic [7:0] b, input bit stop_ok);
    rx_line = 1'b0;
    repeat (BITC) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rx_line = b[i];
      repeat (BITC) @(negedge clk);
    end
    rx_line = stop_ok;
    repeat (BITC) @(negedge clk);
    rx_line = 1'b1;
  endtask

  function automatic logic [111:0] mk_payload(input logic [7:0] seed);
    logic [111:0] p;
    for (int i = 0; i < 14; i++) begin
      logic [7:0] v;
      v = seed + 8'(i * 37);
      if (v == 8'h02) v = 8'h20;
      p[i*8 +: 8] = v;
    end
    return p;
  endfunction

  // driver: builds a frame, predicts the outcome, pushes expected packets
  task automatic send_frame(input logic [111:0] pl, input bit bad_tail, input bit bad_chk,
                            input int glitch_at, input int gap_at, input int gap_len,
                            input int ferr_at, input bit expect_pkt, input string tag);
    logic [7:0]   b [17];
    logic [7:0]   chk;
    logic [135:0] pk;
    b[0] = 8'h02;
    for (int i = 1; i <= 14; i++) b[i] = pl[(i-1)*8 +: 8];
    b[15] = bad_tail ? 8'h13 : 8'h03;
    chk = 8'h00;
    for (int i = 0; i < 15; i++) chk = chk ^ b[i];
    b[16] = bad_chk ? (chk ^ 8'h5A) : chk;
    if (!expect_pkt && b[16] == 8'h02) b[16] = 8'h12;
    if (expect_pkt) begin
      for (int i = 0; i < 17; i++) pk[i*8 +: 8] = b[i];
      exp_q.push_back(pk);
      tag_q.push_back(tag);
    end
    for (int i = 0; i < 17; i++) begin
      if (i == ferr_at) begin
        drive_byte(b[i], 1'b0);
        wait_bits(30);
        return;
      end
      drive_byte(b[i], 1'b1);
      if (i == glitch_at) begin
        wait_bits(1);
        rx_line = 1'b0;
        repeat (6) @(negedge clk);
        wait_bits(1);
      end else if (i == gap_at) wait_bits(gap_len);
      else wait_bits(1);
    end
    wait_bits(4);
  endtask

  // monitor: pops expected packets as the design presents them
  initial begin
    logic [135:0] e, got;
    string t;
    forever begin
      @(negedge clk);
      if (rst_n && pkt_ready && !hold_ack) begin
        if (exp_q.size() == 0) begin
          n_chk++;
          n_fail++;
          $display("FAIL R6 unexpected packet: got ready 1 expected 0");
        end else begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          for (int i = 0; i < 17; i++) begin
            rd_addr = 5'(i);
            @(negedge clk);
            got[i*8 +: 8] = rd_data;
          end
          n_chk++;
          if (got !== e) begin
            n_fail++;
            $display("FAIL %s packet contents: got %h expected %h", t, got, e);
          end
        end
        pkt_ack = 1'b1;
        @(negedge clk);
        pkt_ack = 1'b0;
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9", "reset ready", 32'(pkt_ready), 0);
    check("R9", "reset overrun", 32'(overrun), 0);
    check("R6", "reset err_count", 32'(err_count), 0);
    check("R9", "reset rd_data", 32'(rd_data), 0);

    send_frame(mk_payload(8'h10), 0, 0, -1, -1, 0, -1, 1, "R1");
    check("R4", "packet delivered", 32'(exp_q.size()), 0);
    rd_addr = 5'd20;
    @(negedge clk);
    check("R4", "read beyond packet", 32'(rd_data), 0);

    send_frame(mk_payload(8'hA7), 0, 0, -1, -1, 0, -1, 1, "R3");
    check("R3", "second payload delivered", 32'(exp_q.size()), 0);

    send_frame(mk_payload(8'h55), 0, 0, 5, -1, 0, -1, 1, "R2");
    check("R2", "glitch ignored, packet kept", 32'(exp_q.size()), 0);
    check("R2", "glitch caused no error", 32'(err_count), 0);

    send_frame(mk_payload(8'h31), 1, 0, -1, -1, 0, -1, 0, "R6");
    check("R6", "bad tail marker counted", 32'(err_count), 1);
    check("R6", "bad tail no ready", 32'(pkt_ready), 0);

    send_frame(mk_payload(8'h44), 0, 1, -1, -1, 0, -1, 0, "R6");
    check("R6", "bad check counted", 32'(err_count), 2);

    send_frame(mk_payload(8'h61), 0, 0, -1, -1, 0, 7, 0, "R7");
    check("R7", "low stop no count", 32'(err_count), 2);
    check("R7", "low stop no ready", 32'(pkt_ready), 0);
    send_frame(mk_payload(8'h72), 0, 0, -1, -1, 0, -1, 1, "R7");
    check("R7", "resync after low stop", 32'(exp_q.size()), 0);

    send_frame(mk_payload(8'h83), 0, 0, -1, 5, 25, -1, 0, "R8");
    check("R8", "long gap no count", 32'(err_count), 2);
    check("R8", "long gap no ready", 32'(pkt_ready), 0);
    send_frame(mk_payload(8'h94), 0, 0, -1, 5, 15, -1, 1, "R8");
    check("R8", "short gap tolerated", 32'(exp_q.size()), 0);

    send_frame(mk_payload(8'h1B), 1, 0, -1, -1, 0, -1, 0, "R6");
    check("R6", "third error", 32'(err_count), 3);
    send_frame(mk_payload(8'h2C), 0, 1, -1, -1, 0, -1, 0, "R6");
    check("R6", "counter saturates", 32'(err_count), 3);

    hold_ack = 1'b1;
    send_frame(mk_payload(8'hC3), 0, 0, -1, -1, 0, -1, 0, "R10");
    check("R10", "first held packet ready", 32'(pkt_ready), 1);
    check("R10", "no overrun yet", 32'(overrun), 0);
    send_frame(mk_payload(8'hD9), 0, 0, -1, -1, 0, -1, 1, "R5");
    check("R10", "overrun set", 32'(overrun), 1);
    hold_ack = 1'b0;
    for (int k = 0; k < 200 && pkt_ready; k++) @(negedge clk);
    @(negedge clk);
    check("R5", "second packet captured while held", 32'(exp_q.size()), 0);
    check("R9", "ack clears overrun", 32'(overrun), 0);
    check("R9", "ack clears ready", 32'(pkt_ready), 0);
    rd_addr = 5'd3;
    @(negedge clk);
    check("R9", "buffer zeroed after ack", 32'(rd_data), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule